// File: doc/BRIEF.md
# Triggered Margin Slew Controller

This block produces the 12-bit output code and the output-enable flag for one converter channel. Two target codes are kept in registers: an upper margin and a lower margin. An external trigger pin chooses one of them. When the synchronized trigger changes, the code walks toward the chosen target. It moves a fixed number of LSBs per step and waits a fixed number of timebase ticks between steps, so the analog output ramps instead of jumping. The final step is trimmed so that the code lands exactly on the target.

Configuration comes through a byte-oriented write port. Each write presents an address, an upper data byte and a lower data byte in the same cycle. Codes sit left-aligned in the 16-bit word {upper, lower}, so the code is bits 15..4 of that word. A code written to the direct-code register takes effect at once, with no ramp. A trigger function field can also select a power-switch mode. In that mode the trigger turns the output enable on and off, and the code does not move. The timebase is a one-cycle enable pulse, nominally once per microsecond.

Register map:
- 0x10 holds the upper margin code.
- 0x11 holds the lower margin code.
- 0x12 is the direct code.
- 0x13 is the ramp setup. Lower byte bits 2..0 hold the step exponent and bits 7..4 hold the interval exponent.
- 0x14 is the trigger setup. Upper byte bit 7 is the pin enable, lower byte bits 3..0 are the channel mask, and lower byte bits 5..4 are the function.
- 0x15 is the output setup. Lower byte bit 0 is the output enable.

Top module: `margin_slew_ctrl`

## Requirements
- R1: After reset, code_out is 0, out_en is 0 and busy is 0. All settings are 0: step 1 LSB, interval 1 tick, trigger disabled, output off.
- R2: A write takes effect when wr_en is high, at the clock edge it is sampled on. A code field is bits 15..4 of {wr_msb, wr_lsb}, so the low nibble of wr_lsb is dropped. A write to an address outside 0x10..0x15 changes nothing.
- R3: A write to 0x12 sets code_out at that same edge, with no ramp, and cancels any ramp in progress.
- R4: trig_in passes through two flip-flops before use. The trigger acts on this channel only when all of the following hold: the enable bit (0x14 upper byte bit 7) is 1, mask bit CH_IDX (0x14 lower byte bit CH_IDX) is 1, and the function (0x14 lower byte bits 5..4) is 01, margin-slew. In that case every change of the synchronized trigger starts a ramp. A trigger of 1 ramps toward the upper margin and a trigger of 0 ramps toward the lower margin.
- R5: Each step moves the code by 2^e LSB, where e is 0x13 lower byte bits 2..0. For example, e=3 gives 8 LSB.
- R6: While ramping, one step is taken per 2^k tick pulses, where k is 0x13 lower byte bits 7..4. The first step comes after a full interval from the start of the ramp. With 8-LSB steps every 8 ticks, a ramp from 0 to 0x54A takes 1360 ticks.
- R7: The last step is trimmed so that the code equals the target exactly. This holds in both directions, and the code never passes the target.
- R8: A trigger change during a ramp retargets at once. The code continues from its current value in the new direction, and the interval count restarts.
- R9: busy is 1 while a ramp is active and code_out differs from its target. When busy is 0, code_out changes only through a direct-code write.
- R10: With the enable bit clear, the mask bit clear, or the function set to 00, the trigger does not move the code. Leaving margin-slew mode in the middle of a ramp stops the ramp where it is.
- R11: With function 10, power-switch, and the same enable and mask gating, out_en equals the synchronized trigger. The code does not ramp in this mode.
- R12: Outside power-switch mode, out_en equals 0x15 lower byte bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address |
| wr_msb | input | 8 | Upper data byte |
| wr_lsb | input | 8 | Lower data byte |
| tick_us | input | 1 | Timebase enable pulse, one cycle wide |
| trig_in | input | 1 | Asynchronous trigger pin |
| code_out | output | 12 | Output code |
| out_en | output | 1 | Output enable |
| busy | output | 1 | Ramp in progress |

## Verification
The hardest situation to reach from the ports is a trigger reversal in the middle of a ramp, together with a final step that has to be trimmed on an exact tick. Both depend on how the synchronizer latency lines up with the tick count.

The bench gives the trigger four idle cycles to settle before it issues any tick. It then produces ticks one at a time from a task, so the number of steps taken is known exactly. Vectors with step sizes larger than the remaining gap are used to force the trimmed landing.

// File: rtl/msc_pkg.sv
package msc_pkg;
  localparam int CODE_W     = 12;
  localparam int FIELD_W    = 16;
  localparam int PAD_W      = FIELD_W - CODE_W;
  localparam int STEP_EXP_W = 3;
  localparam int IVL_EXP_W  = 4;
  localparam int IVL_CNT_W  = 1 << IVL_EXP_W;
  localparam int MASK_W     = 4;

  localparam logic [7:0] ADDR_HIGH   = 8'h10;
  localparam logic [7:0] ADDR_LOW    = 8'h11;
  localparam logic [7:0] ADDR_DIRECT = 8'h12;
  localparam logic [7:0] ADDR_RAMP   = 8'h13;
  localparam logic [7:0] ADDR_TRIG   = 8'h14;
  localparam logic [7:0] ADDR_OUT    = 8'h15;

  typedef enum logic [1:0] {
    TRG_OFF    = 2'b00,
    TRG_MARGIN = 2'b01,
    TRG_POWER  = 2'b10,
    TRG_RSVD   = 2'b11
  } trig_fn_e;

  typedef struct packed {
    logic [CODE_W-1:0]     hi_code;
    logic [CODE_W-1:0]     lo_code;
    logic [STEP_EXP_W-1:0] step_exp;
    logic [IVL_EXP_W-1:0]  ivl_exp;
    logic                  trig_en;
    logic                  ch_sel;
    trig_fn_e              trig_fn;
    logic                  out_on;
  } cfg_t;

  // Code field: upper CODE_W bits of the 16-bit data word
  function automatic logic [CODE_W-1:0] field_code(input logic [7:0] msb,
                                                   input logic [7:0] lsb);
    logic [FIELD_W-1:0] word;
    word = {msb, lsb};
    return word[FIELD_W-1:PAD_W];
  endfunction

  function automatic logic [CODE_W-1:0] step_size(input logic [STEP_EXP_W-1:0] e);
    return CODE_W'(1) << e;
  endfunction

  // Last tick count value of an interval of 2^e ticks
  function automatic logic [IVL_CNT_W-1:0] ivl_last(input logic [IVL_EXP_W-1:0] e);
    return (IVL_CNT_W'(1) << e) - IVL_CNT_W'(1);
  endfunction

  // One step toward tgt, trimmed so that it never passes tgt
  function automatic logic [CODE_W-1:0] step_toward(input logic [CODE_W-1:0] cur,
                                                    input logic [CODE_W-1:0] tgt,
                                                    input logic [CODE_W-1:0] stp);
    logic [CODE_W-1:0] gap;
    if (cur < tgt) begin
      gap = tgt - cur;
      return (gap <= stp) ? tgt : cur + stp;
    end else if (cur > tgt) begin
      gap = cur - tgt;
      return (gap <= stp) ? tgt : cur - stp;
    end
    return cur;
  endfunction
endpackage

// File: rtl/msc_regfile.sv
module msc_regfile
  import msc_pkg::*;
#(
  parameter int CH_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_msb,
  input  logic [7:0]        wr_lsb,
  output cfg_t              cfg,
  output logic              direct_wr,
  output logic [CODE_W-1:0] direct_code
);
  logic [CODE_W-1:0] wr_code;

  assign wr_code     = field_code(wr_msb, wr_lsb);
  assign direct_wr   = wr_en && (wr_addr == ADDR_DIRECT);
  assign direct_code = wr_code;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_HIGH: cfg.hi_code <= wr_code;
        ADDR_LOW:  cfg.lo_code <= wr_code;
        ADDR_RAMP: begin
          cfg.step_exp <= wr_lsb[STEP_EXP_W-1:0];
          cfg.ivl_exp  <= wr_lsb[4 +: IVL_EXP_W];
        end
        ADDR_TRIG: begin
          cfg.trig_en <= wr_msb[7];
          cfg.ch_sel  <= wr_lsb[CH_IDX];
          cfg.trig_fn <= trig_fn_e'(wr_lsb[5:4]);
        end
        ADDR_OUT:  cfg.out_on <= wr_lsb[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/msc_trig_sync.sv
module msc_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic chg
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], d};
      last  <= chain[STAGES-1];
    end
  end

  assign q   = chain[STAGES-1];
  assign chg = chain[STAGES-1] ^ last;
endmodule

// File: rtl/msc_slew_engine.sv
module msc_slew_engine
  import msc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 track_start,
  input  logic                 track_allow,
  input  logic                 direct_wr,
  input  logic [CODE_W-1:0]    direct_code,
  input  logic [CODE_W-1:0]    target,
  input  logic [CODE_W-1:0]    step_sz,
  input  logic [IVL_CNT_W-1:0] ivl_end,
  output logic [CODE_W-1:0]    code,
  output logic                 tracking,
  output logic                 at_target,
  output logic                 step_fire
);
  logic [IVL_CNT_W-1:0] tick_cnt;
  logic                 interval_done;

  assign at_target     = (code == target);
  assign interval_done = tick && (tick_cnt == ivl_end);
  assign step_fire     = tracking && track_allow && !at_target && interval_done
                         && !track_start && !direct_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code     <= '0;
      tracking <= 1'b0;
      tick_cnt <= '0;
    end else if (direct_wr) begin
      code     <= direct_code;
      tracking <= 1'b0;
      tick_cnt <= '0;
    end else if (track_start) begin
      tracking <= 1'b1;
      tick_cnt <= '0;
    end else if (!tracking || !track_allow || at_target) begin
      tracking <= 1'b0;
      tick_cnt <= '0;
    end else if (tick) begin
      if (interval_done) begin
        code     <= step_toward(code, target, step_sz);
        tick_cnt <= '0;
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/margin_slew_ctrl.sv
module margin_slew_ctrl
  import msc_pkg::*;
#(
  parameter int CH_IDX      = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_msb,
  input  logic [7:0]        wr_lsb,
  input  logic              tick_us,
  input  logic              trig_in,
  output logic [CODE_W-1:0] code_out,
  output logic              out_en,
  output logic              busy
);
  cfg_t                 cfg;
  logic                 direct_wr;
  logic [CODE_W-1:0]    direct_code;
  logic                 trig_s;
  logic                 trig_chg;
  logic                 chan_sel;
  logic                 margin_mode;
  logic                 power_mode;
  logic                 track_start;
  logic [CODE_W-1:0]    target;
  logic [CODE_W-1:0]    step_sz;
  logic [IVL_CNT_W-1:0] ivl_end;
  logic                 tracking;
  logic                 at_target;
  logic                 step_fire;

  msc_regfile #(.CH_IDX(CH_IDX)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_msb(wr_msb), .wr_lsb(wr_lsb), .cfg(cfg),
    .direct_wr(direct_wr), .direct_code(direct_code)
  );

  msc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(trig_in), .q(trig_s), .chg(trig_chg)
  );

  assign chan_sel    = cfg.trig_en && cfg.ch_sel;
  assign margin_mode = chan_sel && (cfg.trig_fn == TRG_MARGIN);
  assign power_mode  = chan_sel && (cfg.trig_fn == TRG_POWER);
  assign track_start = margin_mode && trig_chg;
  assign target      = trig_s ? cfg.hi_code : cfg.lo_code;
  assign step_sz     = step_size(cfg.step_exp);
  assign ivl_end     = ivl_last(cfg.ivl_exp);

  msc_slew_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick_us), .track_start(track_start),
    .track_allow(margin_mode), .direct_wr(direct_wr), .direct_code(direct_code),
    .target(target), .step_sz(step_sz), .ivl_end(ivl_end),
    .code(code_out), .tracking(tracking), .at_target(at_target),
    .step_fire(step_fire)
  );

  assign busy   = tracking && !at_target;
  assign out_en = power_mode ? trig_s : cfg.out_on;
endmodule

// File: rtl/msc_checker.sv
module msc_checker
  import msc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] code_out,
  input logic              busy,
  input logic              step_fire,
  input logic              direct_wr,
  input logic [CODE_W-1:0] direct_code,
  input logic [CODE_W-1:0] target,
  input logic [CODE_W-1:0] step_sz,
  input logic              power_mode
);
  function automatic logic [CODE_W-1:0] absdiff(input logic [CODE_W-1:0] a,
                                                input logic [CODE_W-1:0] b);
    return (a >= b) ? a - b : b - a;
  endfunction

  AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    direct_wr |=> code_out == $past(direct_code)); // R3
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> absdiff(code_out, $past(code_out)) <= $past(step_sz)); // R5
  AST_NO_OVERSHOOT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && code_out < target) |=> (code_out <= $past(target)) && (code_out > $past(code_out))); // R7
  AST_NO_OVERSHOOT_DN: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && code_out > target) |=> (code_out >= $past(target)) && (code_out < $past(code_out))); // R7
  AST_HOLD_BETWEEN_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_fire && !direct_wr) |=> $stable(code_out)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !direct_wr) |=> $stable(code_out)); // R9
  AST_POWER_NO_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
    power_mode |-> !step_fire); // R11
endmodule

bind margin_slew_ctrl msc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .code_out(code_out), .busy(busy),
  .step_fire(step_fire), .direct_wr(direct_wr), .direct_code(direct_code),
  .target(target), .step_sz(step_sz), .power_mode(power_mode)
);

// File: tb/sim_margin_slew_ctrl.sv
`timescale 1ns/1ps
module sim_margin_slew_ctrl;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [7:0]  wr_msb = '0;
  logic [7:0]  wr_lsb = '0;
  logic        tick_us = 1'b0;
  logic        trig_in = 1'b0;
  logic [11:0] code_out;
  logic        out_en;
  logic        busy;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  margin_slew_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_msb(wr_msb), .wr_lsb(wr_lsb), .tick_us(tick_us), .trig_in(trig_in),
    .code_out(code_out), .out_en(out_en), .busy(busy)
  );

  typedef struct packed {
    logic [2:0]  st;
    logic [3:0]  iv;
    logic [11:0] hi;
    logic [11:0] lo;
    logic [15:0] nt;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{3'd3, 4'd3, 12'h54A, 12'h000, 16'd1360},
    '{3'd3, 4'd3, 12'h54A, 12'h000, 16'd1352},
    '{3'd3, 4'd3, 12'h54A, 12'h000, 16'd7},
    '{3'd0, 4'd0, 12'h005, 12'h000, 16'd3},
    '{3'd7, 4'd1, 12'h100, 12'hFFF, 16'd10},
    '{3'd7, 4'd1, 12'h100, 12'hFFF, 16'd100},
    '{3'd2, 4'd2, 12'h010, 12'h00F, 16'd4}
  };

  // Expected code after n ticks of a ramp from lo toward hi
  function automatic int model_ramp(int lo, int hi, int st, int iv, int n);
    int moved;
    moved = (n / (1 << iv)) * (1 << st);
    if (hi >= lo) return (lo + moved > hi) ? hi : lo + moved;
    return (lo - moved < hi) ? hi : lo - moved;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [7:0] m, input logic [7:0] l);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_msb = m; wr_lsb = l;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic code_wr(input logic [7:0] a, input logic [11:0] c);
    reg_wr(a, c[11:4], {c[3:0], 4'h0});
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_us = 1'b1;
      @(negedge clk); tick_us = 1'b0;
      idle(2);
    end
  endtask

  task automatic set_trig(input logic v);
    @(negedge clk); trig_in = v;
    idle(4);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 code", int'(code_out), 0);
    chk("R1 out_en", int'(out_en), 0);
    chk("R1 busy", int'(busy), 0);

    // R2 / R3: low nibble dropped, direct code immediate
    reg_wr(8'h12, 8'hAB, 8'hCD);
    chk("R3 direct code", int'(code_out), 12'hABC);
    chk("R2 direct no busy", int'(busy), 0);
    reg_wr(8'h7E, 8'hFF, 8'hFF);
    chk("R2 unmapped code", int'(code_out), 12'hABC);
    chk("R2 unmapped out_en", int'(out_en), 0);

    // R12 output bit outside power mode
    reg_wr(8'h15, 8'h00, 8'h01);
    chk("R12 out on", int'(out_en), 1);
    reg_wr(8'h15, 8'h00, 8'h00);
    chk("R12 out off", int'(out_en), 0);

    // Vector table: ramps in margin-slew mode (R4 R5 R6 R7 R9)
    for (int v = 0; v < 7; v++) begin
      int e;
      reg_wr(8'h14, 8'h80, 8'h11);
      reg_wr(8'h13, 8'h00, {VECS[v].iv, 1'b0, VECS[v].st});
      code_wr(8'h10, VECS[v].hi);
      code_wr(8'h11, VECS[v].lo);
      set_trig(1'b0);
      code_wr(8'h12, VECS[v].lo);
      set_trig(1'b1);
      ticks(int'(VECS[v].nt));
      e = model_ramp(int'(VECS[v].lo), int'(VECS[v].hi), int'(VECS[v].st),
                     int'(VECS[v].iv), int'(VECS[v].nt));
      chk($sformatf("R6 R7 vec%0d code", v), int'(code_out), e);
      chk($sformatf("R9 vec%0d busy", v), int'(busy), (e != int'(VECS[v].hi)) ? 1 : 0);
    end

    // R8 retarget mid-ramp
    reg_wr(8'h13, 8'h00, 8'h03);
    code_wr(8'h10, 12'h100);
    code_wr(8'h11, 12'h000);
    set_trig(1'b0);
    code_wr(8'h12, 12'h000);
    set_trig(1'b1);
    ticks(10);
    chk("R5 up 10 steps", int'(code_out), 12'h050);
    chk("R9 busy mid-ramp", int'(busy), 1);
    set_trig(1'b0);
    chk("R8 no jump on retarget", int'(code_out), 12'h050);
    ticks(3);
    chk("R8 reversed", int'(code_out), 12'h038);
    ticks(10);
    chk("R7 clamp at low", int'(code_out), 12'h000);
    chk("R9 busy done", int'(busy), 0);

    // R10 trigger ignored
    code_wr(8'h12, 12'h200);
    code_wr(8'h10, 12'h300);
    code_wr(8'h11, 12'h100);
    reg_wr(8'h14, 8'h00, 8'h11);
    set_trig(1'b1);
    ticks(20);
    chk("R10 enable clear", int'(code_out), 12'h200);
    chk("R10 enable clear busy", int'(busy), 0);
    reg_wr(8'h14, 8'h80, 8'h12);
    set_trig(1'b0);
    ticks(20);
    chk("R10 mask clear", int'(code_out), 12'h200);
    reg_wr(8'h14, 8'h80, 8'h01);
    set_trig(1'b1);
    ticks(20);
    chk("R10 function off", int'(code_out), 12'h200);
    reg_wr(8'h14, 8'h80, 8'h11);
    set_trig(1'b0);
    ticks(2);
    chk("R4 ramp toward low", int'(code_out), 12'h1F0);
    reg_wr(8'h14, 8'h80, 8'h01);
    ticks(5);
    chk("R10 ramp stopped", int'(code_out), 12'h1F0);
    chk("R10 ramp stopped busy", int'(busy), 0);

    // R11 power-switch mode
    reg_wr(8'h14, 8'h80, 8'h21);
    chk("R11 off with trigger low", int'(out_en), 0);
    set_trig(1'b1);
    chk("R11 on with trigger high", int'(out_en), 1);
    ticks(10);
    chk("R11 code untouched", int'(code_out), 12'h1F0);
    chk("R11 no busy", int'(busy), 0);
    @(negedge clk); trig_in = 1'b0;
    @(negedge clk);
    chk("R4 sync stage one", int'(out_en), 1);
    @(negedge clk);
    chk("R4 sync stage two", int'(out_en), 0);
    reg_wr(8'h15, 8'h00, 8'h01);
    chk("R11 power mode ignores out bit", int'(out_en), 0);
    reg_wr(8'h14, 8'h80, 8'h01);
    chk("R12 out bit after leaving power mode", int'(out_en), 1);

    done = 1;
    summary();
    $finish;
  end
endmodule